// File: doc/BRIEF.md
# Split-Access 64-bit Counter Bank

This block holds a bank of 64-bit event counters that are reached over a 32-bit register port. Each counter occupies two adjacent word addresses. Writing the word at the lower address only stages the data. Writing the word at the higher address commits the whole 64-bit value in one cycle, so the counter is never seen half-updated. Reading either word returns that word and freezes the other word of the same counter in a holding register. The following read of the other word returns the frozen copy. Both halves therefore belong to one instant, even while the counter keeps counting between the two reads.

Each counter has a one-bit increment input that adds one per cycle. Two static configuration inputs set how the bus sees the data. One reverses the byte order of every 32-bit bus word, on writes and on reads. The other chooses which half of the counter sits at the lower word address. In every mode the commit still happens on a write to the higher address.

Top module: `ctr_split_bank`

## Requirements
- R1: After a synchronous active-high reset, every counter, staging register and holding register is zero, `bus_rvalid` is low and `bus_rdata` is zero.
- R2: While `inc[i]` is high and no commit targets counter i, counter i grows by one per cycle. It wraps from all ones to zero.
- R3: The word address is `{counter index, offset bit}`. In the default word order, offset 0 holds bits 63..32 and offset 1 holds bits 31..0.
- R4: A write to offset 0 only stores the data in that counter's staging register. The counter keeps its value and keeps counting, and both halves read back unchanged.
- R5: A write to offset 1 loads the whole counter from the staged word and the written word, then clears the staging register. A write to offset 1 with nothing staged therefore gives zero in the staged half.
- R6: When a commit and an increment reach the same counter in the same cycle, the committed value wins and the increment is dropped.
- R7: A read returns its data in `bus_rdata` with `bus_rvalid` high exactly one cycle after `bus_rd`. Otherwise `bus_rdata` is zero. A read that does not consume a held word returns the live word and captures the counter's other word from the same cycle.
- R8: A read of the other offset of a counter that has a held word returns the held word and releases it. Increments between the two reads do not change the held word.
- R9: A second read of the same offset, before the other offset is read, returns live data again and re-captures the other word.
- R10: With `cfg_big_endian` high, byte 0 and byte 3 of each bus word trade places, as do bytes 1 and 2. This applies to `bus_wdata` on entry and to `bus_rdata` on exit.
- R11: With `cfg_lo_first` high, offset 0 holds bits 31..0 and offset 1 holds bits 63..32. A write to offset 0 stages the low half, and a write to offset 1 commits with the written word as the upper half.
- R12: Each counter has its own staging and holding registers. Accesses to one counter do not disturb the staged or held words of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_big_endian | input | 1 | Reverse byte order of bus words |
| cfg_lo_first | input | 1 | Offset 0 holds the low half when high |
| inc | input | NUM_CTR | Per-counter increment strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | $clog2(NUM_CTR)+1 | {counter index, offset bit} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The hardest case to reach is a held word that must stay frozen while the live counter carries across the 32-bit boundary between the two reads. A stale or re-captured copy only shows up when the two halves no longer match. The stimulus reaches this case by committing a value just below the carry and holding the increment high. It reads one half, waits several cycles and then reads the other half, in both word orders. A pseudo-random phase then mixes reads, stages, commits and increments across all counters. The reference model is compared on every clock.

// File: rtl/ctr_split_pkg.sv
package ctr_split_pkg;

    typedef enum logic {
        OFS_LO = 1'b0,
        OFS_HI = 1'b1
    } ofs_e;

    typedef enum logic {
        ORD_HI_FIRST = 1'b0,
        ORD_LO_FIRST = 1'b1
    } word_order_e;

    typedef struct packed {
        logic stage;
        logic commit;
        logic rd;
        ofs_e ofs;
    } cell_req_t;

    function automatic logic maps_upper(input ofs_e ofs, input word_order_e order);
        return (ofs == OFS_LO) ^ (order == ORD_LO_FIRST);
    endfunction

    function automatic ofs_e other_ofs(input ofs_e ofs);
        return (ofs == OFS_LO) ? OFS_HI : OFS_LO;
    endfunction

endpackage

// File: rtl/ctr_split_bswap.sv
module ctr_split_bswap #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    localparam int BYTES = WORD_W / 8;

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign dout[b*8 +: 8] = din[(BYTES-1-b)*8 +: 8];
    end

endmodule

// File: rtl/ctr_split_cell.sv
module ctr_split_cell
    import ctr_split_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  word_order_e       order,
    input  logic              inc,
    input  cell_req_t         req,
    input  logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] rd_word
);
    localparam int CNT_W = 2 * WORD_W;

    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] stage;
    logic [WORD_W-1:0] snap;
    logic              pend;
    ofs_e              pend_ofs;

    logic              req_upper;
    logic [WORD_W-1:0] live_word;
    logic [WORD_W-1:0] other_word;
    logic              hit;
    logic [CNT_W-1:0]  commit_val;

    always_comb begin
        req_upper  = maps_upper(req.ofs, order);
        live_word  = req_upper ? cnt[CNT_W-1:WORD_W] : cnt[WORD_W-1:0];
        other_word = req_upper ? cnt[WORD_W-1:0] : cnt[CNT_W-1:WORD_W];
        hit        = pend && (pend_ofs == req.ofs);
        rd_word    = hit ? snap : live_word;
        commit_val = (order == ORD_LO_FIRST) ? {wword, stage} : {stage, wword};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            stage <= '0;
        end else if (req.commit) begin
            cnt   <= commit_val;
            stage <= '0;
        end else begin
            cnt <= cnt + CNT_W'(inc);
            if (req.stage) begin
                stage <= wword;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap     <= '0;
            pend     <= 1'b0;
            pend_ofs <= OFS_LO;
        end else if (req.rd) begin
            if (hit) begin
                pend <= 1'b0;
            end else begin
                snap     <= other_word;
                pend     <= 1'b1;
                pend_ofs <= other_ofs(req.ofs);
            end
        end
    end

    // R2 / R4: without a commit the counter only moves by the increment
    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        !req.commit |=> cnt == $past(cnt) + CNT_W'($past(inc)));

    // R8: a held word does not change until a read touches this counter
    a_r8_snap_hold: assert property (@(posedge clk) disable iff (rst)
        (pend && !req.rd) |=> (pend && $stable(snap) && $stable(pend_ofs)));

    // R7 / R9: a read that misses the held word arms the opposite offset
    a_r9_rearm: assert property (@(posedge clk) disable iff (rst)
        (req.rd && !hit) |=> (pend && pend_ofs != $past(req.ofs)));

    // R5: after a commit nothing remains staged
    a_r5_stage_empty: assert property (@(posedge clk) disable iff (rst)
        req.commit |=> stage == '0);

endmodule

// File: rtl/ctr_split_port.sv
module ctr_split_port
    import ctr_split_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = $clog2(NUM_CTR) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big_endian,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] rd_words [NUM_CTR],
    output cell_req_t         req      [NUM_CTR],
    output logic [WORD_W-1:0] wword,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0]  idx;
    ofs_e              ofs;
    logic [WORD_W-1:0] wdata_sw;
    logic [WORD_W-1:0] sel_word;
    logic [WORD_W-1:0] sel_sw;
    logic [NUM_CTR-1:0] rd_vec;

    assign idx = addr[ADDR_W-1:1];
    assign ofs = ofs_e'(addr[0]);

    ctr_split_bswap #(.WORD_W(WORD_W)) u_wswap (.din(wdata), .dout(wdata_sw));
    ctr_split_bswap #(.WORD_W(WORD_W)) u_rswap (.din(sel_word), .dout(sel_sw));

    assign wword = big_endian ? wdata_sw : wdata;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_dec
        logic match;
        assign match         = (idx == IDX_W'(i));
        assign req[i].stage  = wr && match && (ofs == OFS_LO);
        assign req[i].commit = wr && match && (ofs == OFS_HI);
        assign req[i].rd     = rd && match;
        assign req[i].ofs    = ofs;
        assign rd_vec[i]     = rd && match;
    end

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_word = rd_words[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd;
            rdata  <= rd ? (big_endian ? sel_sw : sel_word) : '0;
        end
    end

    // R7: read data appears exactly one cycle after the strobe
    a_r7_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
        rd |=> rvalid);

    // R7: without a read the data bus rests at zero
    a_r7_rdata_quiet: assert property (@(posedge clk) disable iff (rst)
        !rd |=> (!rvalid && rdata == '0));

    // R12: a read reaches at most one counter
    a_r12_one_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rd_vec));

endmodule

// File: rtl/ctr_split_bank.sv
module ctr_split_bank
    import ctr_split_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int WORD_W  = 32,
    parameter int ADDR_W  = $clog2(NUM_CTR) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_big_endian,
    input  logic               cfg_lo_first,
    input  logic [NUM_CTR-1:0] inc,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               bus_rvalid
);
    cell_req_t         req_v [NUM_CTR];
    logic [WORD_W-1:0] rdw   [NUM_CTR];
    logic [WORD_W-1:0] wword;
    word_order_e       order;

    assign order = word_order_e'(cfg_lo_first);

    ctr_split_port #(
        .NUM_CTR(NUM_CTR),
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_port (
        .clk       (clk),
        .rst       (rst),
        .big_endian(cfg_big_endian),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rd_words  (rdw),
        .req       (req_v),
        .wword     (wword),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_cell
        ctr_split_cell #(.WORD_W(WORD_W)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .order  (order),
            .inc    (inc[i]),
            .req    (req_v[i]),
            .wword  (wword),
            .rd_word(rdw[i])
        );
    end

endmodule

// File: tb/sim_ctr_split_bank.sv
module sim_ctr_split_bank;
    localparam int NUM    = 4;
    localparam int IDX_W  = 2;
    localparam int ADDR_W = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_be = 1'b0;
    logic              cfg_lf = 1'b0;
    logic [NUM-1:0]    inc = '0;
    logic              b_wr = 1'b0;
    logic              b_rd = 1'b0;
    logic [ADDR_W-1:0] b_addr = '0;
    logic [31:0]       b_wdata = '0;
    logic [31:0]       b_rdata;
    logic              b_rvalid;

    always #5 clk = ~clk;

    ctr_split_bank #(.NUM_CTR(NUM), .WORD_W(32), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .cfg_big_endian(cfg_be), .cfg_lo_first(cfg_lf),
        .inc(inc), .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .bus_rvalid(b_rvalid)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    chk_on = 1'b0;
    bit    done = 1'b0;

    // reference model state
    logic [63:0] m_cnt   [NUM];
    logic [31:0] m_stage [NUM];
    logic [31:0] m_snap  [NUM];
    bit          m_pend  [NUM];
    bit          m_pofs  [NUM];
    logic        exp_rvalid;
    logic [31:0] exp_rdata;

    function automatic logic [31:0] bsw(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    int          mi;
    bit          mo;
    bit          mup;
    logic [31:0] mwd;
    logic [31:0] mrv;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM; i++) begin
                m_cnt[i] = '0; m_stage[i] = '0; m_snap[i] = '0;
                m_pend[i] = 1'b0; m_pofs[i] = 1'b0;
            end
            exp_rvalid = 1'b0;
            exp_rdata  = '0;
        end else begin
            mi  = int'(b_addr[ADDR_W-1:1]);
            mo  = b_addr[0];
            mwd = cfg_be ? bsw(b_wdata) : b_wdata;
            exp_rvalid = b_rd;
            exp_rdata  = '0;
            if (b_rd) begin
                mup = (mo == 1'b0) ^ cfg_lf;
                if (m_pend[mi] && m_pofs[mi] == mo) begin
                    mrv = m_snap[mi];
                    m_pend[mi] = 1'b0;
                end else begin
                    mrv = mup ? m_cnt[mi][63:32] : m_cnt[mi][31:0];
                    m_snap[mi] = mup ? m_cnt[mi][31:0] : m_cnt[mi][63:32];
                    m_pend[mi] = 1'b1;
                    m_pofs[mi] = ~mo;
                end
                exp_rdata = cfg_be ? bsw(mrv) : mrv;
            end
            for (int i = 0; i < NUM; i++) begin
                if (b_wr && mi == i && mo) begin
                    m_cnt[i]   = cfg_lf ? {mwd, m_stage[i]} : {m_stage[i], mwd};
                    m_stage[i] = '0;
                end else begin
                    m_cnt[i] = m_cnt[i] + 64'(inc[i]);
                    if (b_wr && mi == i && !mo) m_stage[i] = mwd;
                end
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk("rvalid", 32'(b_rvalid), 32'(exp_rvalid));
            chk("rdata", b_rdata, exp_rdata);
        end
    end

    task automatic op(input bit w, input bit r, input int idx, input bit ofs, input logic [31:0] d);
        @(negedge clk);
        b_wr = w; b_rd = r; b_addr = {idx[IDX_W-1:0], ofs}; b_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            b_wr = 1'b0; b_rd = 1'b0; b_wdata = '0;
        end
    endtask

    task automatic wr64(input int idx, input logic [31:0] w0, input logic [31:0] w1);
        op(1, 0, idx, 0, w0);
        op(1, 0, idx, 1, w1);
    endtask

    task automatic rd_pair(input int idx, input bit first);
        op(0, 1, idx, first, '0);
        op(0, 1, idx, ~first, '0);
    endtask

    logic [31:0] lfsr = 32'hACE1_2468;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            done = 1'b1;
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_on = 1'b1;
        // R1: reset state, every counter reads zero
        cur_req = "R1";
        idle(2);
        for (int i = 0; i < NUM; i++) rd_pair(i, 0);
        idle(2);
        // R3: default order, offset 0 is upper
        cur_req = "R3";
        wr64(0, 32'h1122_3344, 32'h5566_7788);
        rd_pair(0, 0);
        rd_pair(0, 1);
        idle(1);
        // R4: staging only
        cur_req = "R4";
        op(1, 0, 1, 0, 32'hDEAD_BEEF);
        inc[1] = 1'b1;
        idle(3);
        rd_pair(1, 0);
        idle(1);
        inc[1] = 1'b0;
        op(1, 0, 1, 1, 32'h0000_0010);
        rd_pair(1, 0);
        idle(1);
        // R5: higher word alone commits with empty stage
        cur_req = "R5";
        wr64(2, 32'h0000_00FF, 32'h1);
        op(1, 0, 2, 1, 32'h0000_ABCD);
        rd_pair(2, 0);
        idle(1);
        // R2: counting and wrap
        cur_req = "R2";
        inc[3] = 1'b1;
        idle(20);
        rd_pair(3, 1);
        inc[3] = 1'b0;
        wr64(3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        inc[3] = 1'b1;
        idle(1);
        inc[3] = 1'b0;
        rd_pair(3, 0);
        idle(1);
        // R6: commit beats increment
        cur_req = "R6";
        inc[2] = 1'b1;
        wr64(2, 32'h0000_0007, 32'h0000_0009);
        inc[2] = 1'b0;
        rd_pair(2, 1);
        idle(1);
        // R7 / R8: held word frozen across the carry
        cur_req = "R8";
        wr64(0, 32'h0, 32'hFFFF_FFF8);
        inc[0] = 1'b1;
        op(0, 1, 0, 1, '0);
        idle(20);
        op(0, 1, 0, 0, '0);
        idle(1);
        cur_req = "R7";
        op(0, 1, 0, 0, '0);
        idle(5);
        op(0, 1, 0, 1, '0);
        idle(1);
        // R9: same offset twice re-arms
        cur_req = "R9";
        op(0, 1, 0, 0, '0);
        idle(4);
        op(0, 1, 0, 0, '0);
        idle(4);
        op(0, 1, 0, 1, '0);
        idle(1);
        inc[0] = 1'b0;
        // R12: interleaved counters keep their own state
        cur_req = "R12";
        inc = 4'b1111;
        op(1, 0, 1, 0, 32'h0000_0AAA);
        op(0, 1, 0, 0, '0);
        op(0, 1, 3, 1, '0);
        op(1, 0, 2, 0, 32'h0000_0BBB);
        op(1, 0, 1, 1, 32'h0000_0001);
        op(0, 1, 0, 1, '0);
        op(1, 0, 2, 1, 32'h0000_0002);
        op(0, 1, 3, 0, '0);
        idle(1);
        inc = '0;
        rd_pair(1, 0);
        rd_pair(2, 0);
        idle(1);
        // R10: byte swap both directions
        cur_req = "R10";
        cfg_be = 1'b1;
        idle(1);
        wr64(1, 32'h0102_0304, 32'hA1B2_C3D4);
        rd_pair(1, 0);
        rd_pair(1, 1);
        idle(1);
        cfg_be = 1'b0;
        idle(1);
        // R11: alternate word order with the frozen-carry case
        cur_req = "R11";
        cfg_lf = 1'b1;
        idle(1);
        wr64(2, 32'hFFFF_FFFC, 32'h0000_0003);
        rd_pair(2, 0);
        inc[2] = 1'b1;
        op(0, 1, 2, 0, '0);
        idle(10);
        op(0, 1, 2, 1, '0);
        idle(1);
        inc[2] = 1'b0;
        cfg_lf = 1'b0;
        idle(1);
        // mixed pseudo-random traffic across all requirements
        cur_req = "R12";
        for (int n = 0; n < 600; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            @(negedge clk);
            inc     = lfsr[3:0];
            b_wr    = (lfsr[6:4] == 3'd0) || (lfsr[6:4] == 3'd1);
            b_rd    = !b_wr && lfsr[7];
            b_addr  = lfsr[10:8];
            b_wdata = (lfsr[12:11] == 2'd0) ? 32'hFFFF_FFFE : {lfsr[15:0], lfsr[31:16]};
        end
        inc = '0;
        idle(3);
        chk_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule